// File: doc/BRIEF.md
# Regenerator Section Sink Termination

This block terminates the regenerator section on the receive side of an STM-1 link. An upstream aligner delivers a descrambled byte stream, one byte per clock. With it come a frame-start marker on the first byte of each frame, an out-of-frame flag, and the BIP-8 parity it computed over the previous scrambled frame. The block tracks the byte position inside the 9-row frame from the marker.

From the position and the incoming data, the block does four jobs. It integrates the out-of-frame flag into a loss-of-frame alarm. It rebuilds and validates the 16-byte J0 trace and compares it with an expected trace. It counts frames whose B1 byte does not match the supplied parity. It also presents the section data channel bytes and the auxiliary bytes on strobed outputs.

A trail signal fail output combines loss of signal, loss of frame and trace mismatch, for use by downstream consequent actions. The row length, the alarm integration time, the trace length, the trace persistence and the counter width are parameters.

Top module: `rs_sink_term`

## Requirements
- R1: Loss of frame (lof) is set at the frame start of the LOF_FRAMES-th consecutive frame sampled with oof high. It is cleared at the frame start of the LOF_FRAMES-th consecutive frame sampled with oof low. oof is sampled only in the cycle where sof is high.
- R2: The byte carrying sof is position 0, and positions advance by one per clock. The overhead bytes sit at these positions, where L is ROW_LEN:
  - J0 at 6
  - B1 at L
  - E1 at L+3
  - F1 at L+6
  - D1, D2 and D3 at 2L, 2L+3 and 2L+6
  
  No position is decoded before the first sof.
- R3: In the J0 trace, a byte with bit 7 set opens a multiframe of TRC_LEN bytes, and the other bytes have bit 7 clear. Bits 6:0 of the opening byte hold a CRC-7 with polynomial x^7+x^3+1. The CRC is taken MSB first with a zero start value over all bytes, with the opening byte counted as 8'h80. A multiframe with a wrong CRC is discarded and leaves the persistence count untouched.
- R4: A trace is accepted after PERSIST consecutive valid multiframes with identical content. It is then shown on trace_acc with the first byte in bits [8*TRC_LEN-1 -: 8], and trace_vld is set.
- R5: tim is high when an accepted trace differs from exp_trace, which uses the same byte layout. tim is low while no trace has been accepted.
- R6: When the B1-position byte differs from bip_in, b1_err_cnt increases by one. The counter saturates at 2^CNT_W-1.
- R7: tsf equals los OR lof OR tim, with one cycle of latency.
- R8: D1, D2 and D3 appear on dcc_byte with a one-cycle dcc_vld, one cycle after the byte arrives. dcc_sel is 0, 1 and 2 for D1, D2 and D3 respectively.
- R9: E1 and F1 appear on e1_byte and f1_byte, each with its own one-cycle strobe, one cycle after the byte arrives.
- R10: After reset the following outputs are low or zero: lof, tim, tsf (with los low), trace_vld, b1_err_cnt and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Descrambled byte stream |
| sof | input | 1 | High on the first byte of a frame |
| oof | input | 1 | Out-of-frame flag from the aligner |
| los | input | 1 | Loss of signal |
| bip_in | input | 8 | BIP-8 of the previous frame |
| exp_trace | input | 8*TRC_LEN | Expected J0 trace |
| lof | output | 1 | Loss-of-frame alarm |
| tim | output | 1 | Trace mismatch |
| tsf | output | 1 | Trail signal fail |
| trace_acc | output | 8*TRC_LEN | Accepted J0 trace |
| trace_vld | output | 1 | A trace has been accepted |
| b1_err_cnt | output | CNT_W | B1 errored block count |
| dcc_byte | output | 8 | Section data channel byte |
| dcc_vld | output | 1 | dcc_byte strobe |
| dcc_sel | output | 2 | 0/1/2 for D1/D2/D3 |
| e1_byte | output | 8 | E1 byte |
| e1_vld | output | 1 | E1 strobe |
| f1_byte | output | 8 | F1 byte |
| f1_vld | output | 1 | F1 strobe |

## Verification
The loss-of-frame integrator and the trace monitor both feed the trail signal fail, and their alarms can be active at the same time. The bench first gets a mismatching trace accepted so that tim is high. It then runs a full out-of-frame period to raise lof, followed by a full in-frame period to release it. tsf must stay high throughout, because tim is still active after lof drops. tsf must fall only when the expected trace is changed to match the accepted one. A corrupted-CRC multiframe placed between valid ones shows that a discarded trace neither advances nor resets persistence.

// File: rtl/rs_sink_pkg.sv
package rs_sink_pkg;
  localparam logic [6:0] TRC_POLY = 7'h09;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r;
    logic       fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[6] ^ d[b];
      r  = {r[5:0], 1'b0};
      if (fb) r = r ^ TRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_lof_integ.sv
module rs_lof_integ #(
  parameter int FRAMES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic frm_start,
  input  logic oof,
  output logic lof
);
  localparam int CW = $clog2(FRAMES + 1);

  logic [CW-1:0] bad_q, good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q  <= '0;
      good_q <= '0;
      lof    <= 1'b0;
    end else if (frm_start) begin
      if (oof) begin
        good_q <= '0;
        if (bad_q < CW'(FRAMES)) bad_q <= bad_q + 1'b1;
        if (bad_q >= CW'(FRAMES - 1)) lof <= 1'b1;
      end else begin
        bad_q <= '0;
        if (good_q < CW'(FRAMES)) good_q <= good_q + 1'b1;
        if (good_q >= CW'(FRAMES - 1)) lof <= 1'b0;
      end
    end
  end

  // R1: lof only moves on a frame start with the matching oof level
  p_lof_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(lof) |-> $past(frm_start && oof));
  p_lof_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(lof) |-> $past(frm_start && !oof));
endmodule

// File: rtl/rs_trace_mon.sv
module rs_trace_mon
  import rs_sink_pkg::*;
#(
  parameter int TRC_LEN = 16,
  parameter int PERSIST = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 j0_stb,
  input  logic [7:0]           j0_byte,
  input  logic [8*TRC_LEN-1:0] exp_trace,
  output logic [8*TRC_LEN-1:0] trace_acc,
  output logic                 trace_vld,
  output logic                 tim
);
  localparam int TW = 8 * TRC_LEN;
  localparam int IW = $clog2(TRC_LEN);
  localparam int PW = $clog2(PERSIST + 1);

  logic [TW-9:0]   sh_q;
  logic [IW-1:0]   idx_q;
  logic            run_q;
  logic [6:0]      crc_q, crc_rx_q;
  logic [TW-1:0]   cand_q;
  logic [PW-1:0]   hits_q;

  logic            opener, last, mf_ok;
  logic [6:0]      crc_nx;
  logic [TW-1:0]   full;

  always_comb begin
    opener = j0_byte[7];
    crc_nx = crc7_step(opener ? 7'h00 : crc_q, opener ? 8'h80 : j0_byte);
    full   = {sh_q, j0_byte};
    last   = run_q && !opener && (idx_q == IW'(TRC_LEN - 1));
    mf_ok  = last && (crc_nx == crc_rx_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      idx_q     <= '0;
      run_q     <= 1'b0;
      crc_q     <= '0;
      crc_rx_q  <= '0;
      cand_q    <= '0;
      hits_q    <= '0;
      trace_acc <= '0;
      trace_vld <= 1'b0;
      tim       <= 1'b0;
    end else begin
      tim <= trace_vld && (trace_acc != exp_trace);
      if (j0_stb) begin
        if (opener) begin
          run_q    <= 1'b1;
          idx_q    <= IW'(1);
          crc_q    <= crc_nx;
          crc_rx_q <= j0_byte[6:0];
          sh_q     <= {sh_q[TW-17:0], j0_byte};
        end else if (run_q) begin
          if (last) begin
            run_q <= 1'b0;
            if (mf_ok) begin
              if (full == cand_q) begin
                if (hits_q < PW'(PERSIST)) hits_q <= hits_q + 1'b1;
                if (hits_q == PW'(PERSIST - 1)) begin
                  trace_acc <= full;
                  trace_vld <= 1'b1;
                end
              end else begin
                cand_q <= full;
                hits_q <= PW'(1);
              end
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            crc_q <= crc_nx;
            sh_q  <= {sh_q[TW-17:0], j0_byte};
          end
        end
      end
    end
  end

  // R4: acceptance only ever follows a J0 byte
  p_acc_on_j0_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(trace_vld) |-> $past(j0_stb));
  // R5: no mismatch without an accepted trace
  p_tim_needs_acc_r5: assert property (@(posedge clk) disable iff (rst)
    tim |-> trace_vld);
endmodule

// File: rtl/rs_b1_mon.sv
module rs_b1_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             b1_stb,
  input  logic [7:0]       b1_byte,
  input  logic [7:0]       bip_in,
  output logic [CNT_W-1:0] err_cnt
);
  always_ff @(posedge clk) begin
    if (rst) err_cnt <= '0;
    else if (b1_stb && (b1_byte != bip_in) && !(&err_cnt)) err_cnt <= err_cnt + 1'b1;
  end

  // R6: the count only steps by one and holds at its ceiling
  p_b1_step_r6: assert property (@(posedge clk) disable iff (rst)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));
  p_b1_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (&err_cnt) |=> (&err_cnt));
endmodule

// File: rtl/rs_sink_term.sv
module rs_sink_term #(
  parameter int ROW_LEN    = 270,
  parameter int LOF_FRAMES = 24,
  parameter int TRC_LEN    = 16,
  parameter int PERSIST    = 3,
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           din,
  input  logic                 sof,
  input  logic                 oof,
  input  logic                 los,
  input  logic [7:0]           bip_in,
  input  logic [8*TRC_LEN-1:0] exp_trace,
  output logic                 lof,
  output logic                 tim,
  output logic                 tsf,
  output logic [8*TRC_LEN-1:0] trace_acc,
  output logic                 trace_vld,
  output logic [CNT_W-1:0]     b1_err_cnt,
  output logic [7:0]           dcc_byte,
  output logic                 dcc_vld,
  output logic [1:0]           dcc_sel,
  output logic [7:0]           e1_byte,
  output logic                 e1_vld,
  output logic [7:0]           f1_byte,
  output logic                 f1_vld
);
  localparam int FRAME_LEN = 9 * ROW_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] J0_POS = POS_W'(6);
  localparam logic [POS_W-1:0] B1_POS = POS_W'(ROW_LEN);
  localparam logic [POS_W-1:0] E1_POS = POS_W'(ROW_LEN + 3);
  localparam logic [POS_W-1:0] F1_POS = POS_W'(ROW_LEN + 6);
  localparam logic [POS_W-1:0] D_POS [3] = '{POS_W'(2*ROW_LEN), POS_W'(2*ROW_LEN + 3),
                                            POS_W'(2*ROW_LEN + 6)};

  logic [POS_W-1:0] pos_q, cur_pos;
  logic             pos_vld, live;
  logic             at_j0, at_b1, at_e1, at_f1;
  logic [2:0]       at_d;

  always_comb begin
    cur_pos = sof ? '0 : pos_q;
    live    = sof | pos_vld;
    at_j0   = live && (cur_pos == J0_POS);
    at_b1   = live && (cur_pos == B1_POS);
    at_e1   = live && (cur_pos == E1_POS);
    at_f1   = live && (cur_pos == F1_POS);
  end

  for (genvar g = 0; g < 3; g++) begin : g_dpos
    assign at_d[g] = live && (cur_pos == D_POS[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      pos_vld <= 1'b0;
    end else begin
      if (sof) pos_vld <= 1'b1;
      pos_q <= (cur_pos == POS_W'(FRAME_LEN - 1)) ? '0 : cur_pos + 1'b1;
    end
  end

  rs_lof_integ #(.FRAMES(LOF_FRAMES)) u_lof (
    .clk(clk), .rst(rst), .frm_start(sof), .oof(oof), .lof(lof)
  );

  rs_trace_mon #(.TRC_LEN(TRC_LEN), .PERSIST(PERSIST)) u_trc (
    .clk(clk), .rst(rst), .j0_stb(at_j0), .j0_byte(din), .exp_trace(exp_trace),
    .trace_acc(trace_acc), .trace_vld(trace_vld), .tim(tim)
  );

  rs_b1_mon #(.CNT_W(CNT_W)) u_b1 (
    .clk(clk), .rst(rst), .b1_stb(at_b1), .b1_byte(din), .bip_in(bip_in),
    .err_cnt(b1_err_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tsf      <= 1'b0;
      dcc_vld  <= 1'b0;
      dcc_sel  <= '0;
      dcc_byte <= '0;
      e1_vld   <= 1'b0;
      e1_byte  <= '0;
      f1_vld   <= 1'b0;
      f1_byte  <= '0;
    end else begin
      tsf     <= los | lof | tim;
      dcc_vld <= |at_d;
      e1_vld  <= at_e1;
      f1_vld  <= at_f1;
      if (|at_d) begin
        dcc_byte <= din;
        dcc_sel  <= at_d[2] ? 2'd2 : (at_d[1] ? 2'd1 : 2'd0);
      end
      if (at_e1) e1_byte <= din;
      if (at_f1) f1_byte <= din;
    end
  end

  // R7: loss of signal forces trail fail on the next cycle
  p_tsf_los_r7: assert property (@(posedge clk) disable iff (rst)
    los |=> tsf);
  // R8, R9: overhead strobes never overlap
  p_oh_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dcc_vld, e1_vld, f1_vld}));
endmodule

// File: tb/tb_rs_sink_term.sv
`timescale 1ns/1ps
module tb_rs_sink_term;
  localparam int ROW  = 12;
  localparam int NLOF = 24;
  localparam int TL   = 16;
  localparam int CW   = 3;
  localparam int FL   = 9 * ROW;
  localparam logic [7:0] BIP = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] din = '0, bip_in = BIP;
  logic sof = 1'b0, oof = 1'b0, los = 1'b0;
  logic [8*TL-1:0] exp_trace = '0;
  logic lof, tim, tsf, trace_vld, dcc_vld, e1_vld, f1_vld;
  logic [8*TL-1:0] trace_acc;
  logic [CW-1:0] b1_err_cnt;
  logic [7:0] dcc_byte, e1_byte, f1_byte;
  logic [1:0] dcc_sel;

  int errors = 0, checks = 0;
  int n_dcc = 0, n_e1 = 0, n_f1 = 0;
  logic [7:0] dcc_seen [3];
  logic [7:0] e1_seen, f1_seen;

  always #10 clk = ~clk;

  rs_sink_term #(.ROW_LEN(ROW), .LOF_FRAMES(NLOF), .TRC_LEN(TL), .PERSIST(3), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .din(din), .sof(sof), .oof(oof), .los(los), .bip_in(bip_in),
    .exp_trace(exp_trace), .lof(lof), .tim(tim), .tsf(tsf), .trace_acc(trace_acc),
    .trace_vld(trace_vld), .b1_err_cnt(b1_err_cnt), .dcc_byte(dcc_byte), .dcc_vld(dcc_vld),
    .dcc_sel(dcc_sel), .e1_byte(e1_byte), .e1_vld(e1_vld), .f1_byte(f1_byte), .f1_vld(f1_vld)
  );

  always @(negedge clk) begin
    if (dcc_vld) begin n_dcc++; dcc_seen[dcc_sel] = dcc_byte; end
    if (e1_vld)  begin n_e1++;  e1_seen = e1_byte; end
    if (f1_vld)  begin n_f1++;  f1_seen = f1_byte; end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Trace with a valid CRC-7 in the opening byte (bit division over the whole trace)
  function automatic logic [127:0] mk_trace(input logic [7:0] seed);
    logic [127:0] v;
    logic [6:0] c;
    v = '0;
    for (int i = 1; i < TL; i++) v[127-8*i -: 8] = (seed + 8'(i)) & 8'h7F;
    v[127:120] = 8'h80;
    c = '0;
    for (int k = 127; k >= 0; k--) begin
      if (c[6] ^ v[k]) c = {c[5:0], 1'b0} ^ 7'h09;
      else             c = {c[5:0], 1'b0};
    end
    v[126:120] = c;
    return v;
  endfunction

  task automatic send_frame(input logic o, input logic [7:0] j0, input logic bad_b1,
                            input logic [7:0] e1v, input logic [7:0] f1v, input logic [7:0] db);
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      sof = (i == 0);
      oof = o;
      if (i == 6)                din = j0;
      else if (i == ROW)         din = bad_b1 ? ~BIP : BIP;
      else if (i == ROW + 3)     din = e1v;
      else if (i == ROW + 6)     din = f1v;
      else if (i == 2*ROW)       din = db;
      else if (i == 2*ROW + 3)   din = db + 8'd1;
      else if (i == 2*ROW + 6)   din = db + 8'd2;
      else                       din = 8'h00;
    end
  endtask

  task automatic send_mf(input logic [127:0] t, input logic bad_crc);
    for (int k = 0; k < TL; k++) begin
      logic [7:0] b;
      b = t[127-8*k -: 8];
      if (k == 0 && bad_crc) b = b ^ 8'h01;
      send_frame(1'b0, b, 1'b0, 8'h00, 8'h00, 8'h00);
    end
  endtask

  task automatic t_reset;
    chk("R10 lof", lof, 0);
    chk("R10 tsf", tsf, 0);
    chk("R10 tim", tim, 0);
    chk("R10 trace_vld", trace_vld, 0);
    chk("R10 b1_err_cnt", b1_err_cnt, 0);
    chk("R10 strobes", {dcc_vld, e1_vld, f1_vld}, 0);
  endtask

  task automatic t_overhead;
    n_dcc = 0; n_e1 = 0; n_f1 = 0;
    send_frame(1'b0, 8'h00, 1'b0, 8'h3C, 8'hC3, 8'h10);
    chk("R2 no count before first sof", b1_err_cnt, 0);
    chk("R9 e1 strobes", n_e1, 1);
    chk("R9 f1 strobes", n_f1, 1);
    chk("R9 e1 value", e1_seen, 8'h3C);
    chk("R9 f1 value", f1_seen, 8'hC3);
    chk("R8 dcc strobes", n_dcc, 3);
    chk("R8 D1", dcc_seen[0], 8'h10);
    chk("R8 D2", dcc_seen[1], 8'h11);
    chk("R8 D3", dcc_seen[2], 8'h12);
  endtask

  task automatic t_lof;
    for (int f = 0; f < NLOF - 1; f++) send_frame(1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R1 no lof before threshold", lof, 0);
    send_frame(1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R1 lof at threshold", lof, 1);
    chk("R7 tsf from lof", tsf, 1);
    for (int f = 0; f < NLOF - 1; f++) send_frame(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R1 lof held", lof, 1);
    send_frame(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R1 lof cleared", lof, 0);
    chk("R7 tsf released", tsf, 0);
  endtask

  task automatic t_los;
    @(negedge clk); sof = 1'b0; los = 1'b1;
    @(negedge clk);
    chk("R7 tsf from los", tsf, 1);
    los = 1'b0;
    @(negedge clk);
    chk("R7 tsf after los", tsf, 0);
  endtask

  task automatic t_b1;
    send_frame(1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00);
    chk("R6 one errored block", b1_err_cnt, 1);
    send_frame(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R6 clean frame no count", b1_err_cnt, 1);
    for (int f = 0; f < 8; f++) send_frame(1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00);
    chk("R6 saturation", b1_err_cnt, 7);
  endtask

  task automatic t_trace;
    logic [127:0] t1, t2;
    t1 = mk_trace(8'h21);
    t2 = mk_trace(8'h44);
    exp_trace = t1;
    send_mf(t1, 1'b0);
    send_mf(t1, 1'b0);
    chk("R4 not yet accepted", trace_vld, 0);
    send_mf(t1, 1'b0);
    chk("R4 accepted", trace_vld, 1);
    chk("R4 trace value", trace_acc, t1);
    chk("R5 match no tim", tim, 0);
    send_mf(t2, 1'b0);
    send_mf(t2, 1'b0);
    send_mf(t2, 1'b1);
    chk("R3 bad crc not counted", trace_acc, t1);
    send_mf(t2, 1'b0);
    chk("R3 persistence kept across bad crc", trace_acc, t2);
    chk("R5 mismatch", tim, 1);
    chk("R7 tsf from tim", tsf, 1);
  endtask

  task automatic t_overlap;
    logic [127:0] t2;
    t2 = mk_trace(8'h44);
    for (int f = 0; f < NLOF; f++) send_frame(1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R1 lof with tim", lof, 1);
    for (int f = 0; f < NLOF; f++) send_frame(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00);
    chk("R1 lof cleared under tim", lof, 0);
    chk("R7 tsf held by tim", tsf, 1);
    exp_trace = t2;
    @(negedge clk); sof = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 tim cleared on match", tim, 0);
    chk("R7 tsf cleared", tsf, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_overhead();
    t_lof();
    t_los();
    t_b1();
    t_trace();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule